// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block recovers byte frames from an idle-high asynchronous serial line, using a 16x oversampling tick supplied from outside. Each frame carries a start bit, eight data bits sent least significant bit first, one address-marker bit and a stop bit. A received byte is held in a data register, and three sticky flags report its state: data waiting, bad stop bit and lost frame. Software clears a flag by writing 0 to it through a small register write port.

For links where several receivers share one line, the block has an address filter. While the filter is armed, every frame whose marker bit is 0 is dropped without touching the data register or any flag. The first frame with a marker bit of 1 disarms the filter in hardware and is then received like any other frame. Software can then read the address byte and decide whether to take the data frames that follow or to arm the filter again.

Top module: `mp_async_rx`

## Requirements
- R1: After a synchronous reset, receive enable, filter enable, data-full, framing error, overrun error and the data output are all 0.
- R2: A frame is received only while receive enable is 1, and only after a high-to-low transition on the line; line activity while receive enable is 0 changes no output.
- R3: The start bit is sampled on the 8th oversampling tick after the falling edge; if the line is high there, the receiver goes back to idle and no frame is reported.
- R4: A frame is start (low), 8 data bits LSB first, marker bit, stop bit, each bit sampled at mid-bit. A frame that is accepted while data-full is 0 loads its byte into the data output and sets data-full.
- R5: An accepted frame with a low stop sample sets framing error, and its byte is still loaded when data-full was 0.
- R6: An accepted frame that completes while data-full is 1 sets overrun error and leaves the data output unchanged.
- R7: A write with address 1 clears data-full (bit 0), framing error (bit 1) and overrun error (bit 2) wherever the written bit is 0; a written 1 leaves the flag as it is.
- R8: When a flag is set by hardware in the same cycle as a software clear of it, the flag ends up set.
- R9: Writing receive enable to 0 leaves data-full, framing error and overrun error unchanged.
- R10: While filter enable is 1, a frame whose marker bit is 0 is discarded: the data output and all three flags keep their values and filter enable stays 1.
- R11: While filter enable is 1, a frame whose marker bit is 1 clears filter enable and is then handled as an accepted frame under R4 to R6.
- R12: A write with address 0 sets receive enable from bit 0 and filter enable from bit 1 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 8 | Register write data |
| rx_data | output | 8 | Last accepted data byte |
| rx_full | output | 1 | Data-full flag |
| frame_err | output | 1 | Framing error flag |
| overrun_err | output | 1 | Overrun error flag |
| rx_enable | output | 1 | Current receive enable bit |
| filter_enable | output | 1 | Current address filter bit |

## Verification
A wrong bit counter or a misplaced sample point shows up at the ports one cycle after the stop-bit sample, as a shifted or corrupted byte on rx_data or a framing error that should not be there. A filter that does not hold or does not clear shows up in the same cycle window: flags rise on a frame that should have been dropped, or filter_enable is still 1 after an address frame. Each frame is checked in full right after its stop bit, so one bad state is reported within one frame time. Mixed address and data frames, with the filter armed at random points, are compared against a bench model of the flag rules.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  // Control register (address 0) bit positions
  localparam int unsigned CTRL_RXEN_BIT = 0;
  localparam int unsigned CTRL_FILT_BIT = 1;
  // Status register (address 1) bit positions
  localparam int unsigned STAT_FULL_BIT = 0;
  localparam int unsigned STAT_FERR_BIT = 1;
  localparam int unsigned STAT_OVR_BIT  = 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mp_rx_sync.sv
module mp_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mp_rx_framer.sv
module mp_rx_framer
  import mp_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned OS_RATE   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 line,
  input  logic                 tick,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 mark,
  output logic                 stop_ok
);
  localparam int unsigned SH_W  = DATA_BITS + 1;
  localparam int unsigned CNT_W = $clog2(OS_RATE);
  localparam int unsigned IDX_W = $clog2(SH_W);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SH_W - 1);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SH_W-1:0]   sh_q;
  logic              prev_q;
  logic              done_q;
  logic              stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      prev_q <= line;
      if (!enable) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: begin
            if (prev_q && !line) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (tick) begin
              if (cnt_q == HALF_CNT) begin
                cnt_q <= '0;
                idx_q <= '0;
                st_q  <= line ? RX_IDLE : RX_BITS;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tick) begin
              if (cnt_q == LAST_CNT) begin
                cnt_q <= '0;
                sh_q  <= {line, sh_q[SH_W-1:1]};
                if (idx_q == LAST_IDX) st_q <= RX_STOP;
                else                   idx_q <= idx_q + 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          RX_STOP: begin
            if (tick) begin
              if (cnt_q == LAST_CNT) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
                stop_q <= line;
                st_q   <= RX_IDLE;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done    = done_q;
  assign data    = sh_q[DATA_BITS-1:0];
  assign mark    = sh_q[SH_W-1];
  assign stop_ok = stop_q;
endmodule

// File: rtl/mp_rx_regs.sv
module mp_rx_regs
  import mp_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned REG_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 f_done,
  input  logic [DATA_BITS-1:0] f_data,
  input  logic                 f_mark,
  input  logic                 f_stop_ok,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 full_q,
  output logic                 ferr_q,
  output logic                 ovr_q,
  output logic                 rxen_q,
  output logic                 filt_q
);
  logic ctrl_wr, stat_wr;
  logic discard, accept, load, set_ovr, set_ferr, filt_hw_clr;

  always_comb begin
    ctrl_wr     = wr_en && !wr_addr;
    stat_wr     = wr_en &&  wr_addr;
    discard     = filt_q && !f_mark;
    accept      = f_done && !discard;
    load        = accept && !full_q;
    set_ovr     = accept &&  full_q;
    set_ferr    = accept && !f_stop_ok;
    filt_hw_clr = f_done && filt_q && f_mark;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      rxen_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      if (ctrl_wr) rxen_q <= wr_data[CTRL_RXEN_BIT];
      // hardware disarm wins over a software write in the same cycle
      if (filt_hw_clr)  filt_q <= 1'b0;
      else if (ctrl_wr) filt_q <= wr_data[CTRL_FILT_BIT];

      if (load) data_q <= f_data;

      if (load)                                 full_q <= 1'b1;
      else if (stat_wr && !wr_data[STAT_FULL_BIT]) full_q <= 1'b0;

      if (set_ferr)                             ferr_q <= 1'b1;
      else if (stat_wr && !wr_data[STAT_FERR_BIT]) ferr_q <= 1'b0;

      if (set_ovr)                              ovr_q <= 1'b1;
      else if (stat_wr && !wr_data[STAT_OVR_BIT])  ovr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_async_rx.sv
module mp_async_rx #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  input  logic                 os_tick,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 frame_err,
  output logic                 overrun_err,
  output logic                 rx_enable,
  output logic                 filter_enable
);
  logic                 line_s;
  logic                 frame_done;
  logic [DATA_BITS-1:0] frame_data;
  logic                 frame_mark;
  logic                 frame_stop_ok;

  mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  mp_rx_framer #(.DATA_BITS(DATA_BITS), .OS_RATE(OS_RATE)) u_framer (
    .clk     (clk),
    .rst     (rst),
    .enable  (rx_enable),
    .line    (line_s),
    .tick    (os_tick),
    .done    (frame_done),
    .data    (frame_data),
    .mark    (frame_mark),
    .stop_ok (frame_stop_ok)
  );

  mp_rx_regs #(.DATA_BITS(DATA_BITS), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .f_done    (frame_done),
    .f_data    (frame_data),
    .f_mark    (frame_mark),
    .f_stop_ok (frame_stop_ok),
    .data_q    (rx_data),
    .full_q    (rx_full),
    .ferr_q    (frame_err),
    .ovr_q     (overrun_err),
    .rxen_q    (rx_enable),
    .filt_q    (filter_enable)
  );
endmodule

// File: rtl/mp_async_rx_chk.sv
module mp_async_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 wr_addr,
  input logic                 frame_done,
  input logic                 frame_mark,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_full,
  input logic                 frame_err,
  input logic                 overrun_err,
  input logic                 rx_enable,
  input logic                 filter_enable
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!rx_full && !frame_err && !overrun_err && !rx_enable && !filter_enable)); // R1

  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(rx_enable)); // R2

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !(filter_enable && !frame_mark) && !rx_full) |=> rx_full); // R8

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !(filter_enable && !frame_mark) && rx_full) |=> (overrun_err && $stable(rx_data))); // R6

  AST_RXEN_OFF_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && !frame_done) |=> $stable({rx_full, frame_err, overrun_err})); // R9

  AST_DISCARD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (frame_done && filter_enable && !frame_mark && !wr_en) |=>
      ($stable(rx_data) && $stable({rx_full, frame_err, overrun_err}) && filter_enable)); // R10

  AST_ADDR_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && filter_enable && frame_mark) |=> !filter_enable); // R11
endmodule

bind mp_async_rx mp_async_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .frame_done    (frame_done),
  .frame_mark    (frame_mark),
  .rx_data       (rx_data),
  .rx_full       (rx_full),
  .frame_err     (frame_err),
  .overrun_err   (overrun_err),
  .rx_enable     (rx_enable),
  .filter_enable (filter_enable)
);

// File: tb/mp_async_rx_bench.sv
module mp_async_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rx_data;
  logic       rx_full, frame_err, overrun_err, rx_enable, filter_enable;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model
  logic [7:0] e_data = 8'h00;
  logic e_full = 0, e_ferr = 0, e_ovr = 0, e_en = 0, e_filt = 0;

  mp_async_rx u_mp_async_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
    .overrun_err(overrun_err), .rx_enable(rx_enable), .filter_enable(filter_enable)
  );

  always #10 clk = ~clk;

  // 16x tick: one pulse every 4 clocks, driven away from the rising edge
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rx_data", 32'(rx_data), 32'(e_data));
    chk(req, "rx_full", 32'(rx_full), 32'(e_full));
    chk(req, "frame_err", 32'(frame_err), 32'(e_ferr));
    chk(req, "overrun_err", 32'(overrun_err), 32'(e_ovr));
    chk(req, "rx_enable", 32'(rx_enable), 32'(e_en));
    chk(req, "filter_enable", 32'(filter_enable), 32'(e_filt));
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (os_tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic reg_write(input logic addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!addr) begin
      e_en = d[0]; e_filt = d[1];
    end else begin
      if (!d[0]) e_full = 0;
      if (!d[1]) e_ferr = 0;
      if (!d[2]) e_ovr = 0;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic mark, input logic stop);
    logic [10:0] bits;
    bits = {stop, mark, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      wait_ticks(16);
    end
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  // model of an enabled frame completing
  function automatic void model_frame(input logic [7:0] d, input logic mark, input logic stop);
    if (e_filt && !mark) return;
    if (e_filt && mark) e_filt = 0;
    if (e_full) e_ovr = 1;
    else begin
      e_data = d; e_full = 1;
    end
    if (!stop) e_ferr = 1;
  endfunction

  task automatic rx_frame(input string req, input logic [7:0] d, input logic mark, input logic stop);
    send_frame(d, mark, stop);
    if (e_en) model_frame(d, mark, stop);
    chk_all(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1");

    // R2: frame while disabled is ignored
    rx_frame("R2", 8'hA5, 1'b0, 1'b1);

    // R12: enable receiver through control write
    reg_write(1'b0, 8'h01);
    chk_all("R12");

    // R3: short low pulse is rejected
    rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(24);
    chk_all("R3");

    // R4: normal frame, LSB first
    rx_frame("R4", 8'h3C, 1'b0, 1'b1);
    reg_write(1'b1, 8'hFE);
    chk_all("R7");

    // R5: low stop bit still loads data
    rx_frame("R5", 8'h81, 1'b0, 1'b0);
    // R6: frame while full -> overrun, data kept
    rx_frame("R6", 8'h7E, 1'b1, 1'b1);

    // R7: writing 1 leaves flags; writing 0 to ferr only clears ferr
    reg_write(1'b1, 8'hFF);
    chk_all("R7");
    reg_write(1'b1, 8'hFD);
    chk_all("R7");

    // R9: turning the receiver off keeps flags
    reg_write(1'b0, 8'h00);
    chk_all("R9");
    rx_frame("R2", 8'h11, 1'b1, 1'b1);
    reg_write(1'b1, 8'h00);
    reg_write(1'b0, 8'h01);
    chk_all("R7");

    // R8: hardware set beats a software clear held through the frame
    begin
      bit seen = 0;
      fork
        send_frame(8'hC3, 1'b0, 1'b1);
        begin
          @(negedge clk);
          wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h00;
          for (int c = 0; c < 900; c++) begin
            @(negedge clk);
            if (rx_full) begin
              seen = 1;
              break;
            end
          end
          wr_en = 1'b0;
        end
      join
      chk("R8", "full seen during clear", 32'(seen), 32'd1);
      e_data = 8'hC3; e_full = 1;
      chk_all("R8");
    end
    reg_write(1'b1, 8'h00);

    // R10/R11: filter on, data frames dropped until first address frame
    reg_write(1'b0, 8'h03);
    rx_frame("R10", 8'h12, 1'b0, 1'b1);
    rx_frame("R10", 8'h34, 1'b0, 1'b0);
    rx_frame("R11", 8'h56, 1'b1, 1'b1);
    rx_frame("R11", 8'h78, 1'b0, 1'b1);
    reg_write(1'b1, 8'h00);
    rx_frame("R11", 8'h9A, 1'b0, 1'b1);

    // address frame with filter on while already full: filter clears, overrun
    reg_write(1'b0, 8'h03);
    rx_frame("R11", 8'hBC, 1'b1, 1'b1);
    reg_write(1'b1, 8'h00);

    // mixed random traffic
    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[12:10] == 3'd0) reg_write(1'b0, 8'h03);
      if (r[15:13] == 3'd0) reg_write(1'b1, {5'b0, r[18:16]});
      rx_frame(r[9] ? "R11" : "R10", r[7:0], r[8], (r[21:19] != 3'd0));
      if (r[23:22] == 2'd0) reg_write(1'b1, 8'h00);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule